// File: doc/BRIEF.md
# Reset-Time Bus Agent Identity Capture

Several agents share one front-side bus, and each has four active-low request pins. The system request lines reach those pins in a rotated pattern, so each agent sees them in a different order. During power-on configuration the central agent pulls system request line 0 low. Each agent finds out which of its own pins carries that line at the moment reset goes from active to inactive. The index of that pin becomes the agent's 2-bit identity.

The block passes the request pins through a two-flop synchronizer. It arms itself while reset is low. On the first clock edge after reset is released, it captures the synchronized pin state. Capture happens only then. After that the identity, valid flag and error flag stay fixed until reset is asserted again. If no pin is low at capture, or more than one pin is low, the block flags an error and reports identity 0.

In a two-agent system, agent 0 wires system request 0 to its pin 0 and system request 1 to its pin 1. Agent 1 swaps these two. Pins 2 and 3 are unused but must be held high.

Top module: `bus_agent_id`

## Requirements
- R1: While rst_n is low, id_valid, id_error and agent_id are all 0.
- R2: Capture takes place on the first rising clock edge after rst_n goes high, and id_valid is 1 after that edge. The captured pin state is the one present two or more cycles before that edge, taken through the two-flop synchronizer. Pin changes made at the moment of release do not affect the capture.
- R3: If exactly one pin req_n[k] is low (0 means asserted) at capture, agent_id becomes k and id_error becomes 0.
- R4: If no pin is low at capture, id_error becomes 1 and agent_id becomes 0.
- R5: If two or more pins are low at capture, id_error becomes 1 and agent_id becomes 0.
- R6: After capture, changes on req_n have no effect. agent_id, id_valid and id_error keep their values until rst_n goes low.
- R7: Asserting rst_n again clears id_valid. The next release captures afresh from the pins present at that time.
- R8: In a two-agent system, agent 0 has req_n[1:0] = {sys1, sys0} and agent 1 has req_n[1:0] = {sys0, sys1}, with req_n[3:2] held high. When the central agent asserts only sys0 (low), agent 0 reads identity 0 and agent 1 reads identity 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release triggers capture |
| req_n | input | PINS (4) | Active-low local bus request pins |
| agent_id | output | IDW (2) | Captured agent identity |
| id_valid | output | 1 | Identity captured since the last reset |
| id_error | output | 1 | No pin or more than one pin was low at capture |

## Verification
The hardest case to reach is the exact capture instant, where the synchronizer delay decides which pin state is used. To hit it, the bench inverts every pin on the same half-cycle that it releases reset. It then checks that the identity still matches the pattern held during reset. It sweeps all sixteen pin patterns this way, so single, empty and multiple assertions are all covered. A second instance is wired with the rotated interconnect to show that both agents read different identities from one shared line.

// File: rtl/bus_agent_id.sv
module bus_agent_id #(
  parameter int PINS = 4,
  parameter int SYNC = 2,
  localparam int IDW = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] req_n,
  output logic [IDW-1:0]  agent_id,
  output logic            id_valid,
  output logic            id_error
);

  logic [PINS-1:0] stage [SYNC];
  logic [PINS-1:0] active;
  logic [IDW-1:0]  hit_idx;
  logic            single;
  logic            armed;

  always_ff @(posedge clk) begin
    stage[0] <= req_n;
    for (int i = 1; i < SYNC; i++) stage[i] <= stage[i-1];
  end

  assign active = ~stage[SYNC-1];
  assign single = ($countones(active) == 1);

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < PINS; i++)
      if (active[i]) hit_idx = IDW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_error <= 1'b0;
      agent_id <= '0;
    end else if (!armed) begin
      id_valid <= 1'b1;
      id_error <= !single;
      agent_id <= single ? hit_idx : '0;
    end
  end

  assert_capture_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> id_valid);

  assert_hold_after_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> id_valid && $stable(agent_id) && $stable(id_error));

  assert_error_forces_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    id_error |-> agent_id == '0);

  assert_error_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    id_error |-> id_valid);

endmodule

// File: tb/test_bus_agent_id.sv
module test_bus_agent_id;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic [1:0] agent_id;
  logic       id_valid, id_error;
  logic       sys0 = 1'b1, sys1 = 1'b1;
  logic [1:0] id_a0, id_a1;
  logic       v_a0, v_a1, e_a0, e_a1;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  bus_agent_id i_bus_agent_id (.clk(clk), .rst_n(rst_n), .req_n(req_n),
    .agent_id(agent_id), .id_valid(id_valid), .id_error(id_error));

  bus_agent_id i_bus_agent_id_a0 (.clk(clk), .rst_n(rst_n), .req_n({2'b11, sys1, sys0}),
    .agent_id(id_a0), .id_valid(v_a0), .id_error(e_a0));
  bus_agent_id i_bus_agent_id_a1 (.clk(clk), .rst_n(rst_n), .req_n({2'b11, sys0, sys1}),
    .agent_id(id_a1), .id_valid(v_a1), .id_error(e_a1));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 16; p++) begin
      int lows, exp_id, exp_err;
      @(negedge clk);
      rst_n = 1'b0;
      req_n = 4'(p);
      repeat (3) @(negedge clk);
      chk("R1 valid", id_valid, 0);
      chk("R1 error", id_error, 0);
      chk("R1 id", agent_id, 0);
      lows = 0; exp_id = 0;
      for (int k = 0; k < 4; k++)
        if (((p >> k) & 1) == 0) begin lows++; exp_id = k; end
      exp_err = (lows != 1);
      if (exp_err) exp_id = 0;
      rst_n = 1'b1;
      req_n = ~4'(p);
      @(negedge clk);
      chk("R2 valid", id_valid, 1);
      if (lows == 1)      chk("R3 id", agent_id, exp_id);
      else if (lows == 0) chk("R4 id", agent_id, 0);
      else                chk("R5 id", agent_id, 0);
      if (lows == 1)      chk("R3 error", id_error, 0);
      else if (lows == 0) chk("R4 error", id_error, 1);
      else                chk("R5 error", id_error, 1);
      repeat (3) @(negedge clk);
      req_n = 4'(p) ^ 4'b0101;
      repeat (3) @(negedge clk);
      chk("R6 id", agent_id, exp_id);
      chk("R6 error", id_error, exp_err);
      chk("R6 valid", id_valid, 1);
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 cleared", id_valid, 0);
    req_n = 4'b1011;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 valid", id_valid, 1);
    chk("R7 id", agent_id, 2);
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      rst_n = 1'b0;
      sys0 = (s == 0) ? 1'b0 : 1'b1;
      sys1 = (s == 0) ? 1'b1 : 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 agent0 id", id_a0, s);
      chk("R8 agent1 id", id_a1, 1 - s);
      chk("R8 errors", {30'd0, e_a0, e_a1}, 0);
      chk("R8 valids", {30'd0, v_a0, v_a1}, 3);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule